// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Snapshot and Staged Writes

This block holds wall-clock time as eight packed-BCD byte registers: seconds, minutes, hours, date, month, year, day of week and century. A one-cycle `tick_1hz` strobe advances them. Month lengths, leap years and the 12/24-hour formats are handled as the time rolls over. A serial-bus front end, which is not part of this block, turns its transactions into strobes.

A read transaction starts with `rd_begin`. This copies every counter into a snapshot latch. `rd_byte` then serves bytes from that latch while the live counters keep running. A write transaction starts with `wr_begin`. This copies the live time into a staging buffer. Each `wr_valid` beat replaces one entry of the buffer and marks it as written. A valid stop, `xfer_stop`, loads only the written entries into the counters. An abort, `xfer_abort`, throws the buffer away.

After reset, which models loss of all power, the clock is halted. It stays halted until a write that carries at least one byte has been committed.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the counters hold century 0x20, day of week 0x00, year 0x00, month 0x01, date 0x01, hours 0x80, minutes 0x00 and seconds 0x00, and `running` is 0.
- R2: While `running` is 0, ticks do not change the counters. Committing a write of at least one byte sets `running` to 1, and it stays 1 until reset.
- R3: In 24-hour mode (hours bit 7 = 1, hour value in bits 5:0), each tick advances the time in BCD. Seconds go 59→00 and carry into minutes. Minutes go 59→00 and carry into hours. Hours go 23→00 and carry into the date.
- R4: In 12-hour mode (hours bit 7 = 0), bit 5 is the PM flag and bits 4:0 hold 01 to 12 in BCD. Going from 11 to 12 toggles PM. Going from 12 to 01 keeps PM as it is. Only the step from 11 PM to 12 AM carries into the date.
- R5: A date carry wraps the date to 01 and advances the month after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 in February of a non-leap year.
- R6: A year value divisible by 4 (00 included) gives February 29 days.
- R7: A date carry advances the day of week, which wraps from 06 to 00. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the century in BCD (19 becomes 20).
- R8: `rd_begin` copies all eight counters into the snapshot. `rd_byte` keeps returning those values while ticks continue, until the next `rd_begin`.
- R9: `wr_begin` opens a write. The counters stay untouched until the valid stop, and they keep counting during the write. At the stop, only the entries written with `wr_valid` are loaded. The other bytes keep their live values.
- R10: `xfer_abort` during a write discards the staged bytes and leaves the counters unchanged. A later `xfer_stop` with no open write has no effect.
- R11: After a commit, the next tick advances from the committed values.
- R12: Byte index (`wr_index`, `rd_index`) order is 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (total power loss) |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| rd_begin | input | 1 | Read transaction start; captures the snapshot |
| wr_begin | input | 1 | Write transaction start; loads the staging buffer |
| wr_valid | input | 1 | One data byte for the staging buffer |
| wr_index | input | 3 | Byte index of `wr_byte` |
| wr_byte | input | 8 | BCD data byte |
| xfer_stop | input | 1 | Valid end of transaction; commits a write |
| xfer_abort | input | 1 | Aborted transaction; discards a write |
| rd_index | input | 3 | Byte index into the snapshot |
| rd_byte | output | 8 | Snapshot byte selected by `rd_index` |
| running | output | 1 | Clock is counting |

## Verification
The hardest situation to reach from the ports is a write that is still open while ticks arrive. The live counters must move on. The staged bytes must stay hidden. At the stop, only the written bytes may replace the live ones. The stimulus opens a write, stages one byte, sends ticks, and takes a fresh snapshot before the stop so that the live values are visible. It then commits and checks that the written byte replaced its counter while the bytes it did not write kept counting. The rollover cases, such as a 31-day month, the leap and non-leap Februaries and the century wrap, are each reached by committing a time one second before the boundary and sending a single tick.

// File: rtl/tk_pkg.sv
// tk_pkg: shared widths, byte indices and BCD helper functions for the
// timekeeper. Assumes all stored values are valid packed BCD.
package tk_pkg;
    localparam int TK_DW   = 8;
    localparam int TK_NREG = 8;
    localparam int TK_IW   = $clog2(TK_NREG);

    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DATE = 3;
    localparam int IDX_MON  = 4;
    localparam int IDX_YEAR = 5;
    localparam int IDX_DOW  = 6;
    localparam int IDX_CENT = 7;

    // Increment a two-digit BCD byte (the caller handles wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test for a two-digit BCD year (valid for 2000..2099).
    function automatic logic is_leap(input logic [7:0] y);
        logic [6:0] b;
        b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return (b[1:0] == 2'b00);
    endfunction

    // Last date of a month as BCD.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/tk_advance.sv
// tk_advance: combinational next-second calculator. It takes the live time
// and returns the time one second later, including hour format, month length,
// leap year, day-of-week and century carries. Assumes valid BCD inputs.
module tk_advance
    import tk_pkg::*;
#(
    parameter int DW   = TK_DW,
    parameter int NREG = TK_NREG
) (
    input  logic [NREG-1:0][DW-1:0] cur,
    output logic [NREG-1:0][DW-1:0] nxt
);
    logic       c_min, c_hour, c_day, c_mon, c_year, c_cent;
    logic [7:0] h;

    // Ripple the one-second increment through every field.
    always_comb begin
        nxt    = cur;
        h      = cur[IDX_HOUR];
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        c_cent = 1'b0;

        c_min        = (cur[IDX_SEC] == 8'h59);
        nxt[IDX_SEC] = c_min ? 8'h00 : bcd_inc(cur[IDX_SEC]);

        c_hour = c_min && (cur[IDX_MIN] == 8'h59);
        if (c_min) nxt[IDX_MIN] = (cur[IDX_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur[IDX_MIN]);

        if (c_hour) begin
            if (h[7]) begin
                if (h[5:0] == 6'h23) begin
                    nxt[IDX_HOUR] = {h[7:6], 6'h00};
                    c_day         = 1'b1;
                end else begin
                    nxt[IDX_HOUR] = bcd_inc(h);
                end
            end else if (h[4:0] == 5'h11) begin
                nxt[IDX_HOUR] = {h[7:6], ~h[5], 5'h12};
                c_day         = h[5];
            end else if (h[4:0] == 5'h12) begin
                nxt[IDX_HOUR] = {h[7:6], h[5], 5'h01};
            end else begin
                nxt[IDX_HOUR] = bcd_inc(h);
            end
        end

        if (c_day) begin
            nxt[IDX_DOW] = (cur[IDX_DOW] == 8'h06) ? 8'h00 : bcd_inc(cur[IDX_DOW]);
            if (cur[IDX_DATE] == month_last(cur[IDX_MON], cur[IDX_YEAR])) begin
                nxt[IDX_DATE] = 8'h01;
                c_mon         = 1'b1;
            end else begin
                nxt[IDX_DATE] = bcd_inc(cur[IDX_DATE]);
            end
        end

        if (c_mon) begin
            c_year       = (cur[IDX_MON] == 8'h12);
            nxt[IDX_MON] = c_year ? 8'h01 : bcd_inc(cur[IDX_MON]);
        end

        if (c_year) begin
            c_cent        = (cur[IDX_YEAR] == 8'h99);
            nxt[IDX_YEAR] = c_cent ? 8'h00 : bcd_inc(cur[IDX_YEAR]);
        end

        if (c_cent) nxt[IDX_CENT] = bcd_inc(cur[IDX_CENT]);
    end
endmodule

// File: rtl/tk_shadow.sv
// tk_shadow: host-side buffers. It holds the read snapshot latch, the write
// staging buffer with a per-byte written mask, and the open-write flag. It
// flags a commit on a valid stop of a write that carried data. Assumes the
// strobes for a transaction arrive in separate cycles; abort beats stop.
module tk_shadow
    import tk_pkg::*;
#(
    parameter int DW   = TK_DW,
    parameter int NREG = TK_NREG,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0][DW-1:0] live,
    input  logic                    rd_begin,
    input  logic                    wr_begin,
    input  logic                    wr_valid,
    input  logic [IW-1:0]           wr_index,
    input  logic [DW-1:0]           wr_byte,
    input  logic                    xfer_stop,
    input  logic                    xfer_abort,
    input  logic [IW-1:0]           rd_index,
    output logic [DW-1:0]           rd_byte,
    output logic [NREG-1:0][DW-1:0] stage_q,
    output logic [NREG-1:0]         dirty_q,
    output logic                    commit
);
    logic [NREG-1:0][DW-1:0] snap_q;
    logic                    wr_open_q;

    assign commit  = wr_open_q && xfer_stop && !xfer_abort && (|dirty_q);
    assign rd_byte = snap_q[rd_index];

    // Capture the whole live time when a read starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (rd_begin) snap_q <= live;
    end

    // Track whether a write transaction is open.
    always_ff @(posedge clk) begin
        if (!rst_n)                        wr_open_q <= 1'b0;
        else if (wr_begin)                 wr_open_q <= 1'b1;
        else if (xfer_stop || xfer_abort)  wr_open_q <= 1'b0;
    end

    // Load, patch and clear the staging buffer and its written mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            dirty_q <= '0;
        end else if (wr_begin) begin
            stage_q <= live;
            dirty_q <= '0;
        end else if (xfer_stop || xfer_abort) begin
            dirty_q <= '0;
        end else if (wr_open_q && wr_valid) begin
            stage_q[wr_index] <= wr_byte;
            dirty_q[wr_index] <= 1'b1;
        end
    end
endmodule

// File: rtl/bcd_timekeeper.sv
// bcd_timekeeper: top level. It holds the live BCD counters and the run
// flag, and ties in the next-second logic and the host buffers. A commit has
// priority over a coincident tick; that tick is dropped. Reset stands for
// total power loss: the clock is halted until the first commit.
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter int DW   = TK_DW,
    parameter int NREG = TK_NREG,
    parameter logic [NREG*DW-1:0] RST_TIME = 64'h20_00_00_01_01_80_00_00,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1hz,
    input  logic          rd_begin,
    input  logic          wr_begin,
    input  logic          wr_valid,
    input  logic [IW-1:0] wr_index,
    input  logic [DW-1:0] wr_byte,
    input  logic          xfer_stop,
    input  logic          xfer_abort,
    input  logic [IW-1:0] rd_index,
    output logic [DW-1:0] rd_byte,
    output logic          running
);
    logic [NREG-1:0][DW-1:0] cnt_q;
    logic [NREG-1:0][DW-1:0] nxt;
    logic [NREG-1:0][DW-1:0] stage;
    logic [NREG-1:0]         dirty;
    logic                    commit;
    logic                    run_q;

    assign running = run_q;

    tk_advance #(.DW(DW), .NREG(NREG)) u_adv (
        .cur (cnt_q),
        .nxt (nxt)
    );

    tk_shadow #(.DW(DW), .NREG(NREG)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (cnt_q),
        .rd_begin   (rd_begin),
        .wr_begin   (wr_begin),
        .wr_valid   (wr_valid),
        .wr_index   (wr_index),
        .wr_byte    (wr_byte),
        .xfer_stop  (xfer_stop),
        .xfer_abort (xfer_abort),
        .rd_index   (rd_index),
        .rd_byte    (rd_byte),
        .stage_q    (stage),
        .dirty_q    (dirty),
        .commit     (commit)
    );

    // Run flag: cleared by power loss, set by the first commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (commit) run_q <= 1'b1;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_cnt
        logic [DW-1:0] q;
        // One counter byte: load a written staged byte, else count on a tick.
        always_ff @(posedge clk) begin
            if (!rst_n)                q <= RST_TIME[g*DW +: DW];
            else if (commit) begin
                if (dirty[g])          q <= stage[g];
            end
            else if (run_q && tick_1hz) q <= nxt[g];
        end
        assign cnt_q[g] = q;
    end
endmodule

// File: rtl/tk_checker.sv
// tk_checker: temporal properties of the timekeeper, bound into the top.
// Assumes the host only writes valid BCD values.
module tk_checker #(
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_1hz,
    input logic               rd_begin,
    input logic               xfer_abort,
    input logic [IW-1:0]      rd_index,
    input logic [DW-1:0]      rd_byte,
    input logic               running,
    input logic               commit,
    input logic [NREG*DW-1:0] cnt
);
    logic [7:0] c_sec, c_min, c_hr, c_date, c_mon, c_yr, c_dow, c_cen;
    assign {c_cen, c_dow, c_yr, c_mon, c_date, c_hr, c_min, c_sec} = cnt;

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !commit) |=> $stable(cnt));
    p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
    p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sec <= 8'h59) && (c_sec[3:0] <= 4'd9));
    p_min_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_min <= 8'h59) && (c_min[3:0] <= 4'd9));
    p_hour24_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_hr[7] |-> (c_hr[5:0] <= 6'h23));
    p_hour12_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !c_hr[7] |-> (c_hr[4:0] >= 5'h01 && c_hr[4:0] <= 5'h12 && !c_hr[6]));
    p_date_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_date >= 8'h01) && (c_date <= 8'h31));
    p_month_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mon >= 8'h01) && (c_mon <= 8'h12));
    p_dow_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_dow <= 8'h06);
    p_year_bcd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_yr[7:4] <= 4'd9) && (c_yr[3:0] <= 4'd9) && (c_cen[7:4] <= 4'd9) && (c_cen[3:0] <= 4'd9));
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_begin |=> ($stable(rd_index) -> $stable(rd_byte)));
    p_abort_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_abort && !tick_1hz) |=> $stable(cnt));
    p_commit_runs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> running);
endmodule

bind bcd_timekeeper tk_checker #(.DW(DW), .NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .rd_begin   (rd_begin),
    .xfer_abort (xfer_abort),
    .rd_index   (rd_index),
    .rd_byte    (rd_byte),
    .running    (running),
    .commit     (commit),
    .cnt        (cnt_q)
);

// File: tb/bcd_timekeeper_tb.sv
`timescale 1ns/1ps
module bcd_timekeeper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0, rd_begin = 1'b0, wr_begin = 1'b0, wr_valid = 1'b0;
    logic [2:0] wr_index = '0, rd_index = '0;
    logic [7:0] wr_byte = '0;
    logic       xfer_stop = 1'b0, xfer_abort = 1'b0;
    logic [7:0] rd_byte;
    logic       running;
    int         total = 0, bad = 0, cyc = 0;

    bcd_timekeeper u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .rd_begin(rd_begin),
        .wr_begin(wr_begin), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_byte(wr_byte), .xfer_stop(xfer_stop), .xfer_abort(xfer_abort),
        .rd_index(rd_index), .rd_byte(rd_byte), .running(running)
    );

    always #4 clk = ~clk;

    // Packed time: {century, dow, year, month, date, hours, minutes, seconds}.
    typedef struct packed {
        logic [3:0]  rq;
        logic [63:0] start;
        logic [63:0] expect_t;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 64'h20_00_00_01_01_80_00_58, 64'h20_00_00_01_01_80_00_59},
        '{4'd3, 64'h20_03_24_05_10_80_09_59, 64'h20_03_24_05_10_80_10_00},
        '{4'd3, 64'h20_03_24_05_10_85_59_59, 64'h20_03_24_05_10_86_00_00},
        '{4'd3, 64'h20_03_24_05_10_89_59_59, 64'h20_03_24_05_10_90_00_00},
        '{4'd3, 64'h20_03_24_05_10_A3_59_59, 64'h20_04_24_05_11_80_00_00},
        '{4'd5, 64'h20_02_24_04_30_A3_59_59, 64'h20_03_24_05_01_80_00_00},
        '{4'd5, 64'h20_06_25_01_31_A3_59_59, 64'h20_00_25_02_01_80_00_00},
        '{4'd5, 64'h20_01_25_02_28_A3_59_59, 64'h20_02_25_03_01_80_00_00},
        '{4'd6, 64'h20_01_24_02_28_A3_59_59, 64'h20_02_24_02_29_80_00_00},
        '{4'd6, 64'h20_02_24_02_29_A3_59_59, 64'h20_03_24_03_01_80_00_00},
        '{4'd6, 64'h20_02_00_02_28_A3_59_59, 64'h20_03_00_02_29_80_00_00},
        '{4'd7, 64'h19_05_99_12_31_A3_59_59, 64'h20_06_00_01_01_80_00_00},
        '{4'd4, 64'h20_01_24_03_15_11_59_59, 64'h20_01_24_03_15_32_00_00},
        '{4'd4, 64'h20_01_24_03_15_32_59_59, 64'h20_01_24_03_15_21_00_00},
        '{4'd4, 64'h20_01_24_03_15_31_59_59, 64'h20_02_24_03_16_12_00_00},
        '{4'd4, 64'h20_01_24_03_15_12_59_59, 64'h20_01_24_03_15_01_00_00}
    };

    function automatic string rq_name(input logic [3:0] n);
        case (n)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0; @(negedge clk);
        end
    endtask

    task automatic snap();
        rd_begin = 1'b1; @(negedge clk); rd_begin = 1'b0;
    endtask

    task automatic wr_open();
        wr_begin = 1'b1; @(negedge clk); wr_begin = 1'b0;
    endtask

    task automatic wr_put(input int idx, input logic [7:0] d);
        wr_valid = 1'b1; wr_index = 3'(idx); wr_byte = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic pulse_stop();
        xfer_stop = 1'b1; @(negedge clk); xfer_stop = 1'b0;
    endtask

    task automatic pulse_abort();
        xfer_abort = 1'b1; @(negedge clk); xfer_abort = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input logic [7:0] exp, input string tag);
        rd_index = 3'(idx); #1;
        chk(tag, rd_byte, exp);
    endtask

    task automatic rd_all(input logic [63:0] exp, input string tag);
        for (int i = 0; i < 8; i++) rd_chk(i, exp[i*8 +: 8], $sformatf("%s/R12 idx%0d", tag, i));
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog R1..all act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, read through a snapshot.
        snap();
        rd_all(64'h20_00_00_01_01_80_00_00, "R1");
        chk("R1 running", {7'd0, running}, 8'd0);

        // R2: ticks do not advance a halted clock.
        tick_n(3);
        snap();
        rd_all(64'h20_00_00_01_01_80_00_00, "R2 halted");
        chk("R2 running", {7'd0, running}, 8'd0);

        // R9: single-byte write leaves the other bytes alone; R2 starts the clock.
        wr_open(); wr_put(1, 8'h30); pulse_stop();
        snap();
        rd_all(64'h20_00_00_01_01_80_30_00, "R9 single");
        chk("R2 running after commit", {7'd0, running}, 8'd1);

        // R11: next tick advances from the committed value.
        tick_n(1);
        snap();
        rd_chk(0, 8'h01, "R11 sec");
        rd_chk(1, 8'h30, "R11 min");

        // R8: snapshot holds while counting continues.
        snap();
        tick_n(3);
        rd_chk(0, 8'h01, "R8 held");
        snap();
        rd_chk(0, 8'h04, "R8 refreshed");

        // R9: staged byte hidden until stop while counters keep running.
        wr_open(); wr_put(0, 8'h50);
        tick_n(2);
        snap();
        rd_chk(0, 8'h06, "R9 live before stop");
        pulse_stop();
        snap();
        rd_chk(0, 8'h50, "R9 committed");
        rd_chk(1, 8'h30, "R9 unwritten kept");

        // R10: abort discards; a lone stop has no effect.
        wr_open(); wr_put(1, 8'h45); wr_put(0, 8'h10); pulse_abort();
        snap();
        rd_chk(1, 8'h30, "R10 abort min");
        rd_chk(0, 8'h50, "R10 abort sec");
        pulse_stop();
        snap();
        rd_chk(1, 8'h30, "R10 lone stop");

        // Rollover table: commit a full time, one tick, read all bytes back.
        for (int v = 0; v < NV; v++) begin
            wr_open();
            for (int i = 0; i < 8; i++) wr_put(i, VECS[v].start[i*8 +: 8]);
            pulse_stop();
            tick_n(1);
            snap();
            rd_all(VECS[v].expect_t, $sformatf("%s vec%0d", rq_name(VECS[v].rq), v));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule